// File: doc/BRIEF.md
# Transmit Progress Address Tracker

This block follows one outgoing frame from the moment a transmit slot is launched until its data phase ends. It keeps a halfword address that software can read. At launch the address is loaded with the slot's base address. During transmission it advances one halfword at the pace the selected air rate sets.

At launch the block also stamps the frame. It issues a single halfword write into frame memory that carries the running sequence number, and then bumps that number. It loads a microsecond airtime counter from the frame length and the rate. A one-microsecond strobe drives the counter down. When the counter reaches zero, the block drops busy and pulses done so that the next phase can take over.

A launch request is only honoured while the tracker is idle.

Top module: `txprog_tracker`

## Requirements
- R1: After reset, `busy`, `done` and `stamp_we` are 0, and `live_addr` and `seq_no` are 0.
- R2: A `start` sampled while idle is accepted. On the next cycle `busy` is 1 and `live_addr` equals `slot_addr` shifted right by one.
- R3: The airtime loaded at acceptance is `frame_len`×4 microseconds when `rate_sel` equals 2, and `frame_len`×8 for any other `rate_sel` value. `busy` stays high until that many `us_tick` strobes have been counted.
- R4: Each `us_tick` strobe during the data phase lowers the remaining count by one. If the new count is nonzero and its low 3 bits (rate 2) or low 4 bits (other rates) are all zero, `live_addr` increments by one, wrapping modulo 2^(ADDR_W-1). Otherwise `live_addr` does not change.
- R5: In the cycle after acceptance, `stamp_we` is 1 for exactly one cycle. `stamp_addr` is `slot_addr`+34 (byte address, modulo 2^ADDR_W) and `stamp_data` is the pre-launch sequence number shifted left by 4.
- R6: `seq_no` increments by one modulo 4096 with every stamp, so 0xFFF is followed by 0.
- R7: On the tick that brings the count to zero, `busy` falls and `done` is 1 for exactly one cycle. With `frame_len` 0, `done` rises one cycle after the launch cycle, with no tick needed.
- R8: A `start` while `busy` is 1 is ignored. It causes no stamp write, no change to `seq_no` and no reload of `live_addr`.
- R9: `live_addr` holds its value in any cycle without a `us_tick` strobe, and holds it at all times while idle, whether or not strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| start | input | 1 | Launch request for a slot |
| slot_addr | input | ADDR_W | Byte address of the slot's frame in memory |
| frame_len | input | LEN_W | Frame length in bytes |
| rate_sel | input | 2 | Rate code; 2 selects the 4 µs/byte pace |
| busy | output | 1 | Data phase active |
| done | output | 1 | One-cycle pulse at the end of the data phase |
| live_addr | output | ADDR_W-1 | Live halfword address |
| seq_no | output | SEQ_W | Next sequence number to stamp |
| stamp_we | output | 1 | Memory write strobe for the sequence stamp |
| stamp_addr | output | ADDR_W | Byte address of the stamp write |
| stamp_data | output | 16 | Stamp halfword (sequence number shifted left by 4) |

## Verification
A corrupted airtime count or pace mask shows up on `live_addr` within eight or sixteen strobes. The address steps at the wrong tick, or the final address after the last tick is off. The end of `busy` lands on the wrong strobe. A wrong sequence register is exposed by the very next launch through `stamp_data` and `seq_no`. A mishandled request during busy is exposed in the following cycle through a spurious stamp write or an address reload. The wrap of both the address and the sequence number is driven to its boundary.

// File: rtl/txprog_pkg.sv
package txprog_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    localparam int unsigned FAST_RATE_CODE = 2;
    localparam int unsigned FAST_SHIFT     = 2;
    localparam int unsigned SLOW_SHIFT     = 3;
    localparam int unsigned FAST_PACE_BITS = 3;
    localparam int unsigned SLOW_PACE_BITS = 4;

endpackage

// File: rtl/txprog_seq.sv
module txprog_seq #(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned SEQ_W     = 12,
    parameter int unsigned STAMP_OFS = 34,
    parameter int unsigned SEQ_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic [SEQ_W-1:0]  seq_no,
    output logic              stamp_we,
    output logic [ADDR_W-1:0] stamp_addr,
    output logic [15:0]       stamp_data
);
    localparam int unsigned DATA_W = SEQ_W + SEQ_SHIFT;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (launch) begin
            st_d.we   = 1'b1;
            st_d.addr = slot_addr + ADDR_W'(STAMP_OFS);
            st_d.data = 16'({st_q.seq, {SEQ_SHIFT{1'b0}}});
            st_d.seq  = st_q.seq + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (DATA_W > 16) begin : g_width_bad
        initial $display("txprog_seq: sequence field exceeds halfword");
    end

    assign seq_no     = st_q.seq;
    assign stamp_we   = st_q.we;
    assign stamp_addr = st_q.addr;
    assign stamp_data = st_q.data;
endmodule

// File: rtl/txprog_air.sv
module txprog_air
    import txprog_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             us_tick,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [1:0]       rate_sel,
    output logic             active,
    output logic             done,
    output logic             step
);
    localparam int unsigned CNT_W = LEN_W + SLOW_SHIFT;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             slow;
        logic             done;
    } air_state_t;

    air_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             pace_hit;

    assign cnt_dec = st_q.cnt - 1'b1;

    always_comb begin
        if (st_q.slow) pace_hit = (cnt_dec[SLOW_PACE_BITS-1:0] == '0);
        else           pace_hit = (cnt_dec[FAST_PACE_BITS-1:0] == '0);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        step      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    st_d.phase = PH_DATA;
                    if (rate_sel == 2'(FAST_RATE_CODE)) begin
                        st_d.slow = 1'b0;
                        st_d.cnt  = CNT_W'({frame_len, {FAST_SHIFT{1'b0}}});
                    end else begin
                        st_d.slow = 1'b1;
                        st_d.cnt  = CNT_W'({frame_len, {SLOW_SHIFT{1'b0}}});
                    end
                end
            end
            PH_DATA: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else if (us_tick) begin
                    st_d.cnt = cnt_dec;
                    if (cnt_dec == '0) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else if (pace_hit) begin
                        step = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0, slow: 1'b0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign active = (st_q.phase == PH_DATA);
    assign done   = st_q.done;
endmodule

// File: rtl/txprog_tracker.sv
module txprog_tracker #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned SEQ_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              start,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [1:0]        rate_sel,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-2:0] live_addr,
    output logic [SEQ_W-1:0]  seq_no,
    output logic              stamp_we,
    output logic [ADDR_W-1:0] stamp_addr,
    output logic [15:0]       stamp_data
);
    localparam int unsigned HW_W = ADDR_W - 1;

    typedef struct packed {
        logic [HW_W-1:0] live;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       launch;
    logic       active;
    logic       step;

    assign launch = start && !active;

    txprog_seq #(
        .ADDR_W(ADDR_W),
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .slot_addr (slot_addr),
        .seq_no    (seq_no),
        .stamp_we  (stamp_we),
        .stamp_addr(stamp_addr),
        .stamp_data(stamp_data)
    );

    txprog_air #(
        .LEN_W(LEN_W)
    ) u_air (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .us_tick  (us_tick),
        .frame_len(frame_len),
        .rate_sel (rate_sel),
        .active   (active),
        .done     (done),
        .step     (step)
    );

    always_comb begin
        st_d = st_q;
        if (launch)    st_d.live = slot_addr[ADDR_W-1:1];
        else if (step) st_d.live = st_q.live + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = active;
    assign live_addr = st_q.live;
endmodule

// File: rtl/txprog_chk.sv
module txprog_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned SEQ_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              start,
    input logic [ADDR_W-1:0] slot_addr,
    input logic [LEN_W-1:0]  frame_len,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-2:0] live_addr,
    input logic [SEQ_W-1:0]  seq_no,
    input logic              stamp_we,
    input logic [15:0]       stamp_data
);
    p_launch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && live_addr == $past(slot_addr[ADDR_W-1:1])));

    p_stamp_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (stamp_we && stamp_data == 16'({$past(seq_no), 4'b0000})));

    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_we |-> (seq_no == $past(seq_no) + 1'b1));

    p_addr_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (live_addr == $past(live_addr) ||
                                   live_addr == $past(live_addr) + 1'b1));

    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && frame_len == '0) |=> ##1 done);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !stamp_we);

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !us_tick) |=> $stable(live_addr));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !done) |-> $stable(live_addr));
endmodule

bind txprog_tracker txprog_chk #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SEQ_W (SEQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .start     (start),
    .slot_addr (slot_addr),
    .frame_len (frame_len),
    .busy      (busy),
    .done      (done),
    .live_addr (live_addr),
    .seq_no    (seq_no),
    .stamp_we  (stamp_we),
    .stamp_data(stamp_data)
);

// File: tb/txprog_tracker_test.sv
`timescale 1ns/1ps
module txprog_tracker_test;
    localparam int ADDR_W = 13;
    localparam int LEN_W  = 12;
    localparam int SEQ_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              us_tick = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] slot_addr = '0;
    logic [LEN_W-1:0]  frame_len = '0;
    logic [1:0]        rate_sel = '0;
    logic              busy, done, stamp_we;
    logic [ADDR_W-2:0] live_addr;
    logic [SEQ_W-1:0]  seq_no;
    logic [ADDR_W-1:0] stamp_addr;
    logic [15:0]       stamp_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [SEQ_W-1:0] exp_seq = '0;

    always #2.5 clk = ~clk;

    txprog_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEQ_W(SEQ_W)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
        .slot_addr(slot_addr), .frame_len(frame_len), .rate_sel(rate_sel),
        .busy(busy), .done(done), .live_addr(live_addr), .seq_no(seq_no),
        .stamp_we(stamp_we), .stamp_addr(stamp_addr), .stamp_data(stamp_data)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] slot;
        logic [LEN_W-1:0]  len;
        logic [1:0]        rate;
        logic [ADDR_W-2:0] fin;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{slot: 13'h0100, len: 12'd16, rate: 2'd2, fin: 12'h087},
        '{slot: 13'h0200, len: 12'd16, rate: 2'd0, fin: 12'h107},
        '{slot: 13'h1FFC, len: 12'd20, rate: 2'd1, fin: 12'h007},
        '{slot: 13'h0040, len: 12'd1,  rate: 2'd3, fin: 12'h020},
        '{slot: 13'h0802, len: 12'd3,  rate: 2'd2, fin: 12'h402}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                          input logic [1:0] r);
        @(negedge clk);
        start = 1'b1; slot_addr = a; frame_len = l; rate_sel = r;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 stamp_we", stamp_we, 0);
        chk("R1 live_addr", live_addr, 0);
        chk("R1 seq_no", seq_no, 0);
        rst_n = 1'b1;

        // R9: strobes while idle leave the address alone
        tick(); tick();
        chk("R9 idle tick addr", live_addr, 0);
        chk("R9 idle tick busy", busy, 0);

        // vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int unsigned cnt;
            int unsigned mask;
            logic [ADDR_W-2:0] ea;
            logic [ADDR_W-1:0] esa;
            launch(VEC[v].slot, VEC[v].len, VEC[v].rate);
            ea  = VEC[v].slot[ADDR_W-1:1];
            esa = VEC[v].slot + 13'd34;
            chk("R2 busy", busy, 1);
            chk("R2 live_addr", live_addr, ea);
            chk("R5 stamp_we", stamp_we, 1);
            chk("R5 stamp_addr", stamp_addr, esa);
            chk("R5 stamp_data", stamp_data, {exp_seq, 4'b0000});
            exp_seq = exp_seq + 1'b1;
            chk("R6 seq_no", seq_no, exp_seq);
            cnt  = (VEC[v].rate == 2'd2) ? VEC[v].len * 4 : VEC[v].len * 8;
            mask = (VEC[v].rate == 2'd2) ? 7 : 15;
            for (int t = 1; t <= cnt; t++) begin
                tick();
                if (t < cnt) begin
                    if (((cnt - t) & mask) == 0) ea = ea + 1'b1;
                    chk("R4 live_addr step", live_addr, ea);
                    chk("R3 busy held", busy, 1);
                end
            end
            chk("R7 done at end", done, 1);
            chk("R3 busy fell", busy, 0);
            chk("R4 final addr", live_addr, VEC[v].fin);
            @(negedge clk);
            chk("R7 done one cycle", done, 0);
            chk("R5 single stamp", stamp_we, 0);
        end

        // R9: address holds between strobes during the data phase
        launch(13'h0300, 12'd8, 2'd2);
        exp_seq = exp_seq + 1'b1;
        repeat (8) tick();
        chk("R4 pre-hold addr", live_addr, 12'h181);
        repeat (5) @(negedge clk);
        chk("R9 hold addr", live_addr, 12'h181);
        chk("R9 hold busy", busy, 1);

        // R8: start while busy is ignored
        @(negedge clk);
        start = 1'b1; slot_addr = 13'h0A00; frame_len = 12'd2; rate_sel = 2'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R8 no stamp", stamp_we, 0);
        chk("R8 addr kept", live_addr, 12'h181);
        chk("R8 seq kept", seq_no, exp_seq);
        repeat (24) tick();
        chk("R7 done after 32 ticks", done, 1);
        chk("R4 end addr", live_addr, 12'h183);

        // R7: zero length ends without strobes
        launch(13'h0010, 12'd0, 2'd0);
        exp_seq = exp_seq + 1'b1;
        chk("R7 zero-len busy", busy, 1);
        @(negedge clk);
        chk("R7 zero-len done", done, 1);
        chk("R7 zero-len idle", busy, 0);

        // R6: sequence wrap 0xFFF -> 0
        while (exp_seq != 12'hFFF) begin
            launch(13'h0010, 12'd0, 2'd0);
            exp_seq = exp_seq + 1'b1;
            @(negedge clk);
        end
        launch(13'h0020, 12'd0, 2'd2);
        chk("R6 stamp 0xFFF", stamp_data, 16'hFFF0);
        chk("R6 wrap to 0", seq_no, 0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule